// File: doc/BRIEF.md
# Packed 16-bit Lane Multiplier with Multiply-Add

This block multiplies two 64-bit operands that each carry four 16-bit lanes. Each lane pair produces a 32-bit product, and a 2-bit mode picks which view of the four products is returned. The view can be the low 16 bits of every product, the upper 16 bits of every signed product, or the upper 16 bits of every unsigned product. A fourth view sums neighbouring signed products into two 32-bit lanes.

To get a full 32-bit product per lane, the caller issues one operation in low mode and one in a high mode. The multiply-add view feeds dot-product and filter kernels. The caller presents operands with a valid strobe. One clock later the result appears in a register, and an output valid pulse marks it for one cycle. Between valid inputs the result register holds its value.

Top module: `pmul16x4`

## Requirements
- R1: While synchronous active-low reset is applied, `out_valid` is 0 and `result` is all zeros at the next clock edge.
- R2: `out_valid` is 1 in the cycle after a clock edge that sampled `in_valid` = 1, and 0 after an edge that sampled `in_valid` = 0.
- R3: Mode 2'b00 (low half): for each lane i, result bits [16i+15:16i] equal the low 16 bits of op_a lane i times op_b lane i. Lane i occupies bits [16i+15:16i] of each operand. This value is the same whether the lanes are read as signed or unsigned.
- R4: Mode 2'b01 (signed high half): result lane i holds bits [31:16] of the two's-complement product of the signed lanes.
- R5: Mode 2'b10 (unsigned high half): result lane i holds bits [31:16] of the product of the unsigned lanes.
- R6: Mode 2'b11 (multiply-add): the four lane products are formed signed. result[31:0] is product 0 plus product 1, and result[63:32] is product 2 plus product 3, each sum taken modulo 2^32.
- R7: In mode 2'b11, when every lane of both operands is 16'h8000, each 32-bit half of the result is 32'h80000000.
- R8: `result` keeps its value across any clock edge that samples `in_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| op_a | input | 64 | First operand, four 16-bit lanes |
| op_b | input | 64 | Second operand, four 16-bit lanes |
| mode | input | 2 | View select: 00 low, 01 signed high, 10 unsigned high, 11 multiply-add |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| result | output | 64 | Registered result of the selected view |

## Verification
The block has one register stage, so most internal faults show at the ports on the cycle right after the valid input. A lane extended with the wrong sign shows up only in the high-half and multiply-add views, and only when that lane's top bit is set. A mis-wired lane or a swapped pair in the multiply-add corrupts a fixed 16-bit or 32-bit field of the result. A register that loads without a valid input is seen as a result change during idle cycles. Random operands cover the ordinary cases. Directed cases cover the most negative lane values, multiplication by one, and all-ones operands.

// File: rtl/pmul_pkg.sv
// Shared widths, mode encoding and product array type for the packed multiplier.
// Assumes a lane product fits twice the lane width.
package pmul_pkg;
    localparam int LANE_W = 16;
    localparam int LANES  = 4;
    localparam int PROD_W = 2 * LANE_W;
    localparam int DATA_W = LANE_W * LANES;

    typedef enum logic [1:0] {
        VIEW_LOW  = 2'b00,
        VIEW_SHI  = 2'b01,
        VIEW_UHI  = 2'b10,
        VIEW_MADD = 2'b11
    } view_e;

    typedef logic [LANES-1:0][PROD_W-1:0] prod_arr_t;
endpackage

// File: rtl/pmul_lane.sv
// One lane multiplier: forms the full product of two lane values, reading them
// as signed or unsigned. Assumes the product fits in 2*W bits, which holds for
// both readings.
module pmul_lane #(
    parameter int W = 16
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           is_signed,
    output logic [2*W-1:0] prod
);
    logic [2*W-1:0] a_ext;
    logic [2*W-1:0] b_ext;

    // Widen each operand by sign or zero fill, then multiply at full width
    always_comb begin
        a_ext = {{W{is_signed & a[W-1]}}, a};
        b_ext = {{W{is_signed & b[W-1]}}, b};
        prod  = a_ext * b_ext;
    end
endmodule

// File: rtl/pmul_view.sv
// Picks the output view from the lane products: the low halves, the high
// halves, or sums of neighbouring product pairs. Assumes the products were
// formed signed for the signed-high and multiply-add views.
module pmul_view
    import pmul_pkg::*;
(
    input  prod_arr_t          prods,
    input  logic [1:0]         mode,
    output logic [DATA_W-1:0]  view
);
    localparam int PAIRS = LANES / 2;

    logic [DATA_W-1:0] low_v;
    logic [DATA_W-1:0] high_v;
    logic [DATA_W-1:0] madd_v;

    genvar gi;
    generate
        for (gi = 0; gi < LANES; gi++) begin : g_half
            // Cut each product into its low and high halves
            always_comb begin
                low_v[gi*LANE_W +: LANE_W]  = prods[gi][LANE_W-1:0];
                high_v[gi*LANE_W +: LANE_W] = prods[gi][PROD_W-1:LANE_W];
            end
        end
        for (gi = 0; gi < PAIRS; gi++) begin : g_pair
            // Sum a neighbouring product pair, wrapping at the product width
            always_comb begin
                madd_v[gi*PROD_W +: PROD_W] = prods[2*gi] + prods[2*gi+1];
            end
        end
    endgenerate

    // Route the view chosen by the mode
    always_comb begin
        unique case (view_e'(mode))
            VIEW_LOW:  view = low_v;
            VIEW_SHI,
            VIEW_UHI:  view = high_v;
            VIEW_MADD: view = madd_v;
            default:   view = low_v;
        endcase
    end
endmodule

// File: rtl/pmul16x4.sv
// Packed lane multiplier top: four lane multipliers share one mode, a view
// selector picks the output, and one register stage holds the result.
// Assumes the inputs are stable while in_valid is sampled. The result is held
// between valid inputs.
module pmul16x4
    import pmul_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [1:0]        mode,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);
    prod_arr_t         prods;
    logic              lane_signed;
    logic [DATA_W-1:0] view;

    // Only the unsigned high view reads the lanes as unsigned
    always_comb lane_signed = (view_e'(mode) != VIEW_UHI);

    genvar gl;
    generate
        for (gl = 0; gl < LANES; gl++) begin : g_lane
            pmul_lane #(.W(LANE_W)) u_lane (
                .a         (op_a[gl*LANE_W +: LANE_W]),
                .b         (op_b[gl*LANE_W +: LANE_W]),
                .is_signed (lane_signed),
                .prod      (prods[gl])
            );
        end
    endgenerate

    pmul_view u_view (
        .prods (prods),
        .mode  (mode),
        .view  (view)
    );

    // Output stage: load on valid input, pulse valid for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= view;
        end
    end
endmodule

// File: rtl/pmul16x4_chk.sv
// Port-level checker for the packed multiplier, bound to the top module.
// Assumes the default 64-bit width.
module pmul16x4_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [63:0] op_a,
    input logic [63:0] op_b,
    input logic [1:0]  mode,
    input logic        out_valid,
    input logic [63:0] result
);
    localparam logic [63:0] ONES16 = 64'h0001_0001_0001_0001;
    localparam logic [63:0] MINS16 = 64'h8000_8000_8000_8000;

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));
    a_r3_low_times_one: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'b00 && op_b == ONES16) |=> (result == $past(op_a)));
    a_r5_unsigned_high_times_one: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'b10 && op_b == ONES16) |=> (result == 64'd0));
    a_r7_madd_most_negative: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'b11 && op_a == MINS16 && op_b == MINS16)
        |=> (result == 64'h8000_0000_8000_0000));
endmodule

bind pmul16x4 pmul16x4_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .mode      (mode),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/sim_pmul16x4.sv
// Bench for the packed lane multiplier. It drives seeded random and directed
// vectors and checks them against a model written from the requirements.
module sim_pmul16x4;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [1:0]  mode = 2'b00;
    logic        out_valid;
    logic [63:0] result;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic        exp_v = 1'b0;
    logic [63:0] exp_r = '0;

    always #10 clk = ~clk;

    pmul16x4 u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a),
        .op_b(op_b), .mode(mode), .out_valid(out_valid), .result(result)
    );

    // Model of the selected view (R3 to R7)
    function automatic logic [63:0] model(input logic [1:0] m,
                                          input logic [63:0] a,
                                          input logic [63:0] b);
        logic [63:0] r;
        longint      p[4];
        r = '0;
        for (int i = 0; i < 4; i++) begin
            longint sa, sb, ua, ub;
            sa = longint'($signed(a[16*i +: 16]));
            sb = longint'($signed(b[16*i +: 16]));
            ua = longint'({48'd0, a[16*i +: 16]});
            ub = longint'({48'd0, b[16*i +: 16]});
            p[i] = (m == 2'b10) ? ua * ub : sa * sb;
        end
        case (m)
            2'b00, 2'b01, 2'b10: begin
                for (int i = 0; i < 4; i++) begin
                    logic [63:0] pw;
                    pw = 64'(p[i]);
                    r[16*i +: 16] = (m == 2'b00) ? pw[15:0] : pw[31:16];
                end
            end
            default: begin
                logic [63:0] s0, s1;
                s0 = 64'(p[0] + p[1]);
                s1 = 64'(p[2] + p[3]);
                r  = {s1[31:0], s0[31:0]};
            end
        endcase
        return r;
    endfunction

    function automatic string mode_tag(input logic [1:0] m);
        case (m)
            2'b00:   return "R3";
            2'b01:   return "R4";
            2'b10:   return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Compare the last edge's outputs, then drive the next input set
    task automatic step(input logic v, input logic [1:0] m,
                        input logic [63:0] a, input logic [63:0] b, input string tag);
        @(negedge clk);
        check("R2 out_valid", {63'd0, out_valid}, {63'd0, exp_v});
        check(tag, result, exp_r);
        in_valid = v; mode = m; op_a = a; op_b = b;
        exp_v = v;
        if (v) exp_r = model(m, a, b);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] ra, rb;
        logic [1:0]  rm;
        logic        rv;
        void'($urandom(32'd20251229));
        in_valid = 1'b1; op_a = '1; op_b = '1; mode = 2'b11;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset out_valid", {63'd0, out_valid}, 64'd0);
        check("R1 reset result", result, 64'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        exp_v = 1'b0; exp_r = '0;

        // Directed corners
        step(1, 2'b11, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, "R6");
        step(0, 2'b00, '0, '0, "R7 madd all most-negative");
        step(0, 2'b01, '1, '1, "R8 hold after idle");
        step(1, 2'b00, 64'h1234_8765_FFFF_0003, 64'h0001_0001_0001_0001, "R8 hold");
        step(1, 2'b01, 64'h8000_7FFF_FFFF_8000, 64'h8000_7FFF_0001_7FFF, "R3 low times one");
        step(1, 2'b10, 64'hFFFF_8000_FFFF_0001, 64'hFFFF_8000_0001_FFFF, "R4 signed high corners");
        step(1, 2'b00, 64'hFFFF_8000_1234_00FF, 64'hFFFF_8000_4321_0101, "R5 unsigned high corners");
        step(1, 2'b11, 64'h7FFF_8000_7FFF_FFFF, 64'h7FFF_7FFF_7FFF_FFFF, "R3 low signed/unsigned alike");
        step(0, 2'b00, '0, '0, "R6 madd mixed signs");

        // Seeded random traffic with random idle gaps
        for (int n = 0; n < 2000; n++) begin
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            rm = 2'($urandom_range(0, 3));
            rv = ($urandom_range(0, 3) != 0);
            step(rv, rm, ra, rb, exp_v ? mode_tag(mode) : "R8 hold random");
        end
        step(0, 2'b00, '0, '0, "R2 final");
        step(0, 2'b00, '0, '0, "R8 final hold");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule